// File: doc/BRIEF.md
# MIDI Note to Latch Mapper

This block turns decoded MIDI channel messages into bit updates on eight external 8-bit output latches. A separate serial receiver delivers each complete message as one valid pulse carrying the status byte, the first data byte (note or controller number) and the second data byte (velocity or controller value). The block keeps a shadow image of every latch. A note maps through lookup tables to one latch and a pair of masks. A note-on ORs the set mask into that latch's image. A note-off ANDs the clear mask into it.

After each change, the index of the changed latch goes into a small circular command queue. A latch write sequencer outside this block drains the queue: it reads the head index and pops it, then copies that latch's image onto the physical bus. An All Notes Off controller message zeroes every image and reloads the queue with all latch indices, so that every latch gets rewritten. Status bytes are matched on the upper nibble only, so any channel is accepted.

Top module: `note_latch_mapper`

## Requirements
- R1: After reset, every latch image is zero, the queue is empty (count 0, empty flag high, full flag low) and the overflow flag is low.
- R2: A message with status upper nibble 9 and nonzero velocity on a mapped note ORs the note's set mask into the selected latch image. The new image is visible after the clock edge that sampled the message.
- R3: A message with status upper nibble 8 on a mapped note ANDs the note's clear mask into the selected latch image, whatever the velocity.
- R4: A status-9 message with velocity zero has exactly the effect of a status-8 message on the same note.
- R5: A note whose selector is zero is unmapped. A note-on or note-off for it changes no image and queues nothing.
- R6: Each note-on or note-off on a mapped note pushes that latch's index (selector minus one, 0..7) at the queue tail. The head output presents the oldest entry, and a pop removes it.
- R7: Queue pointers wrap from slot 7 back to slot 0, so first-in first-out order holds across any number of pushes and pops.
- R8: A push while the queue holds 8 entries and no pop is taken in the same cycle is dropped. The overflow flag then goes high and stays high until reset.
- R9: A status with upper nibble B and controller number 123 (All Notes Off) sets all eight images to zero and leaves the queue holding latch indices 0,1,...,7 in that order, with count 8. The overflow flag is not changed.
- R10: Default mapping, with BASE_NOTE = 36: note n in 36..99 selects latch (n-36)/8 with bit (n-36) mod 8. The set mask is that single bit and the clear mask is its complement. Every other note is unmapped.
- R11: A pop while the queue is empty does nothing. Messages with any other status nibble, and controller messages with any other controller number, change neither the images nor the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | One-cycle strobe: a decoded message is present |
| msg_status | input | 8 | Status byte of the message |
| msg_data1 | input | 7 | Note number or controller number |
| msg_data2 | input | 7 | Velocity or controller value |
| q_pop | input | 1 | Sequencer has taken the head entry |
| q_head | output | 3 | Latch index at the queue head |
| q_empty | output | 1 | Queue holds no entries |
| q_full | output | 1 | Queue holds 8 entries |
| q_count | output | 4 | Number of queued entries |
| overflow | output | 1 | Sticky: a push was dropped on a full queue |
| latch_img | output | 64 | All latch images, latch k on bits 8k+7..8k |

## Verification
Note-on messages are sent on notes in different latches and at different bit positions, including the first and last mapped notes, to show that the selector and mask tables are decoded rather than fixed. Note-off is sent once as status 8 and once as status 9 with velocity zero on bits that are set, so that set, clear and the velocity-zero alias can be told apart. Notes just outside the mapped range, other status nibbles and a non-matching controller show that only the intended messages act. Long push/pop runs across the wrap point, a flood past eight entries and All Notes Off over a partly filled queue separate correct ordering, drop-on-full and the full reload.

// File: rtl/nlm_pkg.sv
package nlm_pkg;
  localparam int NUM_LATCH = 8;
  localparam int LATCH_W   = 8;
  localparam int NOTE_W    = 7;
  localparam int NUM_NOTES = 1 << NOTE_W;
  localparam int SEL_W     = $clog2(NUM_LATCH + 1);
  localparam int IDX_W     = $clog2(NUM_LATCH);
  localparam logic [NOTE_W-1:0] CC_ALL_OFF = 7'd123;

  typedef enum logic [3:0] {
    ST_NOTE_OFF = 4'h8,
    ST_NOTE_ON  = 4'h9,
    ST_CTRL     = 4'hB
  } status_kind_e;

  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [LATCH_W-1:0] set_m;
    logic [LATCH_W-1:0] clr_m;
  } map_entry_t;

  // Map one note to its selector and masks; selector 0 = unmapped.
  function automatic map_entry_t build_entry(input int note, input int base);
    map_entry_t e;
    int rel;
    rel = note - base;
    e.sel   = '0;
    e.set_m = '0;
    e.clr_m = '1;
    if (rel >= 0 && rel < NUM_LATCH * LATCH_W) begin
      e.sel   = SEL_W'(rel / LATCH_W + 1);
      e.set_m = LATCH_W'(1) << (rel % LATCH_W);
      e.clr_m = ~e.set_m;
    end
    return e;
  endfunction

  function automatic logic [LATCH_W-1:0] apply_on(input logic [LATCH_W-1:0] img,
                                                  input logic [LATCH_W-1:0] m);
    return img | m;
  endfunction

  function automatic logic [LATCH_W-1:0] apply_off(input logic [LATCH_W-1:0] img,
                                                   input logic [LATCH_W-1:0] m);
    return img & m;
  endfunction
endpackage

// File: rtl/nlm_msg_decode.sv
module nlm_msg_decode
  import nlm_pkg::*;
(
  input  logic              valid,
  input  logic [7:0]        status,
  input  logic [NOTE_W-1:0] data1,
  input  logic [NOTE_W-1:0] data2,
  output logic              evt_on,
  output logic              evt_off,
  output logic              evt_all_off
);
  logic [3:0] kind;
  logic       vel_zero;

  assign kind     = status[7:4];
  assign vel_zero = (data2 == '0);

  always_comb begin
    evt_on      = 1'b0;
    evt_off     = 1'b0;
    evt_all_off = 1'b0;
    if (valid) begin
      unique case (kind)
        ST_NOTE_ON: begin
          evt_on  = !vel_zero;
          evt_off = vel_zero;
        end
        ST_NOTE_OFF: evt_off = 1'b1;
        ST_CTRL:     evt_all_off = (data1 == CC_ALL_OFF);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nlm_map_rom.sv
module nlm_map_rom
  import nlm_pkg::*;
#(
  parameter int BASE_NOTE = 36
) (
  input  logic [NOTE_W-1:0] note,
  output map_entry_t        entry
);
  map_entry_t table_q [NUM_NOTES];

  for (genvar i = 0; i < NUM_NOTES; i++) begin : g_rom
    assign table_q[i] = build_entry(i, BASE_NOTE);
  end

  assign entry = table_q[note];
endmodule

// File: rtl/nlm_latch_bank.sv
module nlm_latch_bank
  import nlm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_on,
  input  logic                         upd_off,
  input  logic [IDX_W-1:0]             upd_idx,
  input  logic [LATCH_W-1:0]           set_m,
  input  logic [LATCH_W-1:0]           clr_m,
  input  logic                         clear_all,
  output logic [NUM_LATCH*LATCH_W-1:0] img_flat
);
  for (genvar k = 0; k < NUM_LATCH; k++) begin : g_latch
    logic [LATCH_W-1:0] img_q;
    logic               hit;

    assign hit = (upd_idx == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (!rst_n || clear_all) begin
        img_q <= '0;
      end else if (hit && upd_on) begin
        img_q <= apply_on(img_q, set_m);
      end else if (hit && upd_off) begin
        img_q <= apply_off(img_q, clr_m);
      end
    end

    assign img_flat[k*LATCH_W +: LATCH_W] = img_q;
  end
endmodule

// File: rtl/nlm_cmd_queue.sv
module nlm_cmd_queue
  import nlm_pkg::*;
#(
  parameter int DEPTH = NUM_LATCH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [IDX_W-1:0]   push_idx,
  input  logic               pop,
  input  logic               refill,
  output logic [IDX_W-1:0]   head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic               overflow,
  output logic               push_taken,
  output logic               push_dropped
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             pop_taken;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_taken    = pop && (cnt_q != '0);
  assign push_taken   = push && ((cnt_q != CNT_W'(DEPTH)) || pop_taken);
  assign push_dropped = push && !push_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (refill) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CNT_W'(DEPTH);
    end else begin
      if (push_dropped) ovf_q <= 1'b1;
      if (pop_taken)    rd_q  <= ptr_next(rd_q);
      if (push_taken)   wr_q  <= ptr_next(wr_q);
      if (push_taken && !pop_taken)      cnt_q <= cnt_q + 1'b1;
      else if (pop_taken && !push_taken) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_q[s] <= '0;
      end else if (refill) begin
        mem_q[s] <= IDX_W'(s % NUM_LATCH);
      end else if (push_taken && wr_q == PTR_W'(s)) begin
        mem_q[s] <= push_idx;
      end
    end
  end

  assign head     = mem_q[rd_q];
  assign count    = cnt_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/note_latch_mapper.sv
module note_latch_mapper
  import nlm_pkg::*;
#(
  parameter int BASE_NOTE = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msg_valid,
  input  logic [7:0]  msg_status,
  input  logic [6:0]  msg_data1,
  input  logic [6:0]  msg_data2,
  input  logic        q_pop,
  output logic [2:0]  q_head,
  output logic        q_empty,
  output logic        q_full,
  output logic [3:0]  q_count,
  output logic        overflow,
  output logic [63:0] latch_img
);
  localparam int CNT_W = $clog2(NUM_LATCH + 1);

  logic       evt_on, evt_off, evt_all_off;
  map_entry_t entry;
  logic       mapped;
  logic       upd_on, upd_off;
  logic       push_evt, unmapped_evt;
  logic [IDX_W-1:0] upd_idx;
  logic       push_taken, push_dropped;
  logic [CNT_W-1:0] cnt;

  nlm_msg_decode u_dec (
    .valid       (msg_valid),
    .status      (msg_status),
    .data1       (msg_data1),
    .data2       (msg_data2),
    .evt_on      (evt_on),
    .evt_off     (evt_off),
    .evt_all_off (evt_all_off)
  );

  nlm_map_rom #(.BASE_NOTE(BASE_NOTE)) u_rom (
    .note  (msg_data1),
    .entry (entry)
  );

  assign mapped       = (entry.sel != '0);
  assign upd_on       = evt_on  && mapped;
  assign upd_off      = evt_off && mapped;
  assign push_evt     = upd_on || upd_off;
  assign unmapped_evt = (evt_on || evt_off) && !mapped;
  assign upd_idx      = IDX_W'(entry.sel - 1'b1);

  nlm_latch_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_on    (upd_on),
    .upd_off   (upd_off),
    .upd_idx   (upd_idx),
    .set_m     (entry.set_m),
    .clr_m     (entry.clr_m),
    .clear_all (evt_all_off),
    .img_flat  (latch_img)
  );

  nlm_cmd_queue #(.DEPTH(NUM_LATCH)) u_q (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (push_evt),
    .push_idx     (upd_idx),
    .pop          (q_pop),
    .refill       (evt_all_off),
    .head         (q_head),
    .count        (cnt),
    .overflow     (overflow),
    .push_taken   (push_taken),
    .push_dropped (push_dropped)
  );

  assign q_count = cnt;
  assign q_empty = (cnt == '0);
  assign q_full  = (cnt == CNT_W'(NUM_LATCH));
endmodule

// File: rtl/note_latch_mapper_chk.sv
module note_latch_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        q_pop,
  input logic        q_empty,
  input logic        q_full,
  input logic [3:0]  q_count,
  input logic        overflow,
  input logic [63:0] latch_img,
  input logic        push_evt,
  input logic        unmapped_evt,
  input logic        evt_all_off,
  input logic        push_dropped
);
  // R9: All Notes Off empties every image and loads all eight entries
  a_r9_all_off_reload: assert property (@(posedge clk) disable iff (!rst_n)
    evt_all_off |=> (latch_img == 64'd0) && (q_count == 4'd8));

  // R8: overflow never clears once set
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8: overflow can only rise from a full queue
  a_r8_rise_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(q_full));

  // R8: a dropped push leaves the count at 8
  a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_dropped |=> q_full);

  // R5: unmapped notes touch neither the images nor the queue
  a_r5_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_evt && !q_pop) |=> ($stable(q_count) && $stable(latch_img)));

  // R6: outside reload the count moves by at most one per cycle
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_all_off |=> ((q_count == $past(q_count)) ||
                      (q_count == $past(q_count) + 4'd1) ||
                      (q_count + 4'd1 == $past(q_count))));

  // R11: popping an empty queue with no push keeps it empty
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && q_pop && !push_evt && !evt_all_off) |=> q_empty);

  // R6: a push never lands while the count reads above eight
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= 4'd8);
endmodule

bind note_latch_mapper note_latch_mapper_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .q_pop        (q_pop),
  .q_empty      (q_empty),
  .q_full       (q_full),
  .q_count      (q_count),
  .overflow     (overflow),
  .latch_img    (latch_img),
  .push_evt     (push_evt),
  .unmapped_evt (unmapped_evt),
  .evt_all_off  (evt_all_off),
  .push_dropped (push_dropped)
);

// File: tb/note_latch_mapper_bench.sv
`timescale 1ns/1ps
module note_latch_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [7:0]  msg_status = '0;
  logic [6:0]  msg_data1 = '0;
  logic [6:0]  msg_data2 = '0;
  logic        q_pop = 1'b0;
  logic [2:0]  q_head;
  logic        q_empty, q_full, overflow;
  logic [3:0]  q_count;
  logic [63:0] latch_img;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_img [8];
  int         m_q [$];
  logic       m_ovf = 1'b0;

  always #4 clk = ~clk;

  note_latch_mapper u_note_latch_mapper (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_status(msg_status),
    .msg_data1(msg_data1), .msg_data2(msg_data2), .q_pop(q_pop),
    .q_head(q_head), .q_empty(q_empty), .q_full(q_full), .q_count(q_count),
    .overflow(overflow), .latch_img(latch_img)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = m_img[k];
    return f;
  endfunction

  task automatic check_state(input string req);
    chk(latch_img == model_flat(), req, latch_img, model_flat());
    chk(q_count == 4'(m_q.size()), req, 64'(q_count), 64'(m_q.size()));
    chk(overflow == m_ovf, req, 64'(overflow), 64'(m_ovf));
  endtask

  // Send one message and update the reference model from the requirements
  task automatic send(input logic [7:0] st, input int d1, input int d2, input string req);
    int rel;
    logic is_on, is_off;
    @(negedge clk);
    msg_valid = 1'b1; msg_status = st; msg_data1 = 7'(d1); msg_data2 = 7'(d2);
    @(negedge clk);
    msg_valid = 1'b0;
    is_on  = (st[7:4] == 4'h9) && (d2 != 0);
    is_off = (st[7:4] == 4'h8) || ((st[7:4] == 4'h9) && (d2 == 0));
    rel = d1 - 36;
    if ((is_on || is_off) && rel >= 0 && rel < 64) begin
      if (is_on) m_img[rel/8] = m_img[rel/8] | (8'd1 << (rel%8));
      else       m_img[rel/8] = m_img[rel/8] & ~(8'd1 << (rel%8));
      if (m_q.size() < 8) m_q.push_back(rel/8);
      else m_ovf = 1'b1;
    end
    if (st[7:4] == 4'hB && d1 == 123) begin
      for (int k = 0; k < 8; k++) m_img[k] = 8'h00;
      m_q.delete();
      for (int k = 0; k < 8; k++) m_q.push_back(k);
    end
    check_state(req);
  endtask

  task automatic pop_one(input string req);
    int e;
    @(negedge clk);
    if (m_q.size() > 0) begin
      e = m_q.pop_front();
      chk(q_head == 3'(e), req, 64'(q_head), 64'(e));
    end
    q_pop = 1'b1;
    @(negedge clk);
    q_pop = 1'b0;
    check_state(req);
  endtask

  task automatic drain(input string req);
    while (m_q.size() > 0) pop_one(req);
  endtask

  task automatic t_reset();
    chk(latch_img == 64'd0, "R1", latch_img, 64'd0);
    chk(q_empty && !q_full && q_count == 0, "R1", 64'(q_count), 64'd0);
    chk(!overflow, "R1", 64'(overflow), 64'd0);
  endtask

  task automatic t_note_on();
    send(8'h90, 36, 100, "R2 R10 first note");
    send(8'h93, 65, 1, "R2 R10 latch3 bit5");
    send(8'h9F, 99, 127, "R2 R10 last note");
    chk(latch_img[7:0] == 8'h01, "R10", 64'(latch_img[7:0]), 64'h01);
    chk(latch_img[63:56] == 8'h80, "R10", 64'(latch_img[63:56]), 64'h80);
    drain("R6 order after note-on");
  endtask

  task automatic t_note_off();
    send(8'h90, 45, 64, "R2 setup");
    send(8'h90, 46, 64, "R2 setup");
    send(8'h80, 45, 64, "R3 status-8 clears bit");
    chk(latch_img[15:8] == 8'h04, "R3", 64'(latch_img[15:8]), 64'h04);
    send(8'h95, 46, 0, "R4 velocity zero as off");
    chk(latch_img[15:8] == 8'h00, "R4", 64'(latch_img[15:8]), 64'h00);
    send(8'h80, 46, 0, "R3 off on clear bit");
    drain("R6 drain after off");
  endtask

  task automatic t_ignored();
    send(8'h90, 35, 90, "R5 below range");
    send(8'h90, 100, 90, "R5 above range");
    send(8'h80, 10, 0, "R5 off unmapped");
    send(8'hA0, 40, 90, "R11 other status");
    send(8'hB0, 7, 90, "R11 other controller");
    send(8'hE2, 50, 10, "R11 pitch status");
    pop_one("R11 pop on empty");
    chk(q_empty, "R11", 64'(q_empty), 64'd1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 14; i++) begin
      send(8'h90, 36 + (i * 9) % 64, 5, "R7 wrap push");
      if (i % 2 == 1) pop_one("R7 wrap pop");
    end
    drain("R7 wrap drain");
  endtask

  task automatic t_full();
    for (int i = 0; i < 10; i++) send(8'h80, 36 + i * 6, 0, "R8 flood");
    chk(q_full && overflow, "R8", {62'd0, q_full, overflow}, 64'd3);
    pop_one("R8 pop after drop");
    drain("R8 order kept");
    chk(overflow, "R8 sticky", 64'(overflow), 64'd1);
  endtask

  task automatic t_all_off();
    send(8'h90, 50, 9, "R9 setup");
    send(8'h90, 90, 9, "R9 setup");
    pop_one("R9 setup pop");
    send(8'hB7, 123, 0, "R9 all notes off");
    chk(q_full, "R9", 64'(q_full), 64'd1);
    drain("R9 reload order 0..7");
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m_img[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_note_on();
    t_note_off();
    t_ignored();
    t_wrap();
    t_full();
    t_all_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule